// File: doc/BRIEF.md
# Split-Mode Precision Gamma Palette

This block is the per-pipe colour lookup stage of a display pipeline. It holds two cascaded 512-entry tables of 10-bit RGB values: a linearising (degamma) table followed by an output gamma table. Each pixel channel indexes the first table with its upper nine bits. The upper nine bits of that result then index the second table. A channel that arrives at full scale takes its value from a per-channel overflow limit register instead of the second table.

The host reaches both tables through one index register and one data port. An auto-advance option lets a driver stream a whole table with back-to-back data writes. A mode register selects a legacy 8-bit palette instead. In that mode a single 256-entry table is used, and host words carry one byte per channel.

Top module: `gamma_palette`

## Requirements
- R1: After a synchronous reset the index register reads 0 (split flag, auto-advance and index all clear), the mode register (0x1C) reads 1, the three limit registers (0x10, 0x14, 0x18) read 0xFFFF and `pix_out_valid` is low. Reset leaves the table contents unchanged.
- R2: A write to the index register (0x00) loads bit 31 as the split flag, bit 15 as auto-advance and bits 9:0 as the entry index. A read returns the same fields in the same positions, with all other bits zero.
- R3: In split mode (mode bit 0 = 1), a data-port (0x04) word carries red in bits 29:20, green in 19:10 and blue in 9:0. A data-port read returns the entry at the current index on `reg_rdata` in the cycle after `reg_rd`.
- R4: With auto-advance set, every data-port write or read moves the index up by one, and index 1023 advances to 0. With auto-advance clear, the index is unchanged.
- R5: With the split flag set, indices 0..511 address the degamma table and 512..1023 address the gamma table at index minus 512. With the split flag clear, index bit 9 is ignored and every access reaches the degamma table.
- R6: At power-up, entry i of both tables holds floor(i*1023/511) on all three channels.
- R7: In split mode, each output channel is gamma[degamma[c[9:1]][9:1]] for the matching input channel c.
- R8: In split mode, an input channel equal to 1023 outputs bits 15:6 of that channel's limit register (red 0x10, green 0x14, blue 0x18) instead of the gamma result.
- R9: In legacy mode (mode bit 0 = 0), data words carry red, green and blue in bits 23:16, 15:8 and 7:0. A byte b is stored as b*4 in degamma entries 0..255 and reads back as b. The lookup uses c[9:2] and outputs the stored 10-bit value. The gamma table and the limit registers play no part.
- R10: Writing 0 to the index register clears the split flag and auto-advance, and sets the index to 0.
- R11: `pix_out_valid` repeats `pix_in_valid` delayed by two clock edges, and the output channels belong to the pixel presented two edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host register read strobe |
| reg_addr | input | 5 | Host byte offset |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Read result, valid the cycle after `reg_rd` and held until the next read |
| pix_in_valid | input | 1 | Input pixel qualifier |
| pix_in_r | input | 10 | Input red |
| pix_in_g | input | 10 | Input green |
| pix_in_b | input | 10 | Input blue |
| pix_out_valid | output | 1 | Output pixel qualifier |
| pix_out_r | output | 10 | Output red |
| pix_out_g | output | 10 | Output green |
| pix_out_b | output | 10 | Output blue |

## Verification
The checker assumes that the host never raises `reg_wr` and `reg_rd` in the same cycle. The design gives the write priority and drops the read, and the checker flags any overlap. The checker also assumes that the limit registers and the mode are not rewritten while a pixel is in flight. The bench drives every register access as a single-cycle strobe in its own cycle. It reprograms mode and limits only while no pixel is in the pipeline, so every lookup result is defined by one configuration.

// File: rtl/gpal_pkg.sv
package gpal_pkg;
  localparam int CH_W      = 10;
  localparam int TBL_AW    = 9;
  localparam int LIM_W     = 16;
  localparam int NUM_CH    = 3;
  localparam int LEG_W     = 8;
  localparam int REG_AW    = 5;
  localparam int SPLIT_POS = 31;
  localparam int INC_POS   = 15;
  localparam int OFF_INDEX = 'h00;
  localparam int OFF_DATA  = 'h04;
  localparam int OFF_LIM   = 'h10;
  localparam int OFF_MODE  = 'h1C;

  // linear ramp spanning the full output code range over the table depth
  function automatic int ramp_value(input int idx, input int depth, input int width);
    return (idx * ((1 << width) - 1)) / (depth - 1);
  endfunction
endpackage

// File: rtl/gpal_ram.sv
module gpal_ram #(
  parameter int AW = gpal_pkg::TBL_AW,
  parameter int DW = gpal_pkg::CH_W
) (
  input  logic          clk,
  input  logic          a_en,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic [AW-1:0] b_addr,
  output logic [DW-1:0] b_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = DW'(gpal_pkg::ramp_value(i, DEPTH, DW));
  end

  // host port: write or read, registered read data
  always_ff @(posedge clk) begin
    if (a_en) begin
      if (a_we) mem[a_addr] <= a_wdata;
      else      a_rdata     <= mem[a_addr];
    end
  end

  // pixel port: read every cycle
  always_ff @(posedge clk) begin
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/gpal_host.sv
module gpal_host #(
  parameter int CW  = gpal_pkg::CH_W,
  parameter int AW  = gpal_pkg::TBL_AW,
  parameter int CLW = gpal_pkg::LIM_W,
  parameter int NCH = gpal_pkg::NUM_CH,
  parameter int LW  = gpal_pkg::LEG_W,
  parameter int RAW = gpal_pkg::REG_AW
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          reg_wr,
  input  logic                          reg_rd,
  input  logic [RAW-1:0]                reg_addr,
  input  logic [31:0]                   reg_wdata,
  output logic [31:0]                   reg_rdata,
  output logic [1:0]                    ram_en,
  output logic                          ram_we,
  output logic [AW-1:0]                 ram_addr,
  output logic [NCH-1:0][CW-1:0]        ram_wdata,
  input  logic [1:0][NCH-1:0][CW-1:0]   ram_rdata,
  output logic                          mode_split,
  output logic [NCH-1:0][CLW-1:0]       limits
);
  import gpal_pkg::*;
  localparam int IW = AW + 1;

  logic [IW-1:0]          idx_q;
  logic                   split_q, inc_q, mode_q;
  logic [NCH-1:0][CLW-1:0] clamp_q;
  logic                   rd_ram_q, rd_bank_q, rd_leg_q;
  logic [31:0]            hold_q, reg_mux;
  logic                   sel_data, acc_wr, acc_rd, bank;

  assign sel_data = (reg_addr == RAW'(OFF_DATA));
  assign acc_wr   = reg_wr & sel_data;
  assign acc_rd   = reg_rd & ~reg_wr & sel_data;
  assign bank     = split_q & idx_q[AW];

  assign ram_en[0] = (acc_wr | acc_rd) & ~bank;
  assign ram_en[1] = (acc_wr | acc_rd) & bank;
  assign ram_we    = acc_wr;
  assign ram_addr  = idx_q[AW-1:0];
  assign mode_split = mode_q;
  assign limits     = clamp_q;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      if (mode_q) ram_wdata[c] = reg_wdata[CW*(NCH-c)-1 -: CW];
      else        ram_wdata[c] = {reg_wdata[LW*(NCH-c)-1 -: LW], {(CW-LW){1'b0}}};
    end
  end

  // value of non-table registers at the read address
  always_comb begin
    reg_mux = '0;
    if (reg_addr == RAW'(OFF_INDEX)) begin
      reg_mux[SPLIT_POS] = split_q;
      reg_mux[INC_POS]   = inc_q;
      reg_mux[IW-1:0]    = idx_q;
    end else if (reg_addr == RAW'(OFF_MODE)) begin
      reg_mux[0] = mode_q;
    end
    for (int c = 0; c < NCH; c++) begin
      if (reg_addr == RAW'(OFF_LIM + 4*c)) reg_mux[CLW-1:0] = clamp_q[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q    <= '0;
      split_q  <= 1'b0;
      inc_q    <= 1'b0;
      mode_q   <= 1'b1;
      clamp_q  <= {NCH{{CLW{1'b1}}}};
      rd_ram_q <= 1'b0;
      rd_bank_q <= 1'b0;
      rd_leg_q <= 1'b0;
      hold_q   <= '0;
    end else begin
      if (reg_wr && reg_addr == RAW'(OFF_INDEX)) begin
        idx_q   <= reg_wdata[IW-1:0];
        split_q <= reg_wdata[SPLIT_POS];
        inc_q   <= reg_wdata[INC_POS];
      end else if ((acc_wr || acc_rd) && inc_q) begin
        idx_q <= idx_q + 1'b1;
      end
      if (reg_wr && reg_addr == RAW'(OFF_MODE)) mode_q <= reg_wdata[0];
      for (int c = 0; c < NCH; c++) begin
        if (reg_wr && reg_addr == RAW'(OFF_LIM + 4*c)) clamp_q[c] <= reg_wdata[CLW-1:0];
      end
      if (reg_rd && !reg_wr) begin
        rd_ram_q  <= sel_data;
        rd_bank_q <= bank;
        rd_leg_q  <= ~mode_q;
        hold_q    <= reg_mux;
      end
    end
  end

  always_comb begin
    reg_rdata = hold_q;
    if (rd_ram_q) begin
      reg_rdata = '0;
      for (int c = 0; c < NCH; c++) begin
        if (rd_leg_q) reg_rdata[LW*(NCH-c)-1 -: LW] = ram_rdata[rd_bank_q][c][CW-1 -: LW];
        else          reg_rdata[CW*(NCH-c)-1 -: CW] = ram_rdata[rd_bank_q][c];
      end
    end
  end
endmodule

// File: rtl/gpal_lookup.sv
module gpal_lookup #(
  parameter int CW  = gpal_pkg::CH_W,
  parameter int AW  = gpal_pkg::TBL_AW,
  parameter int CLW = gpal_pkg::LIM_W,
  parameter int NCH = gpal_pkg::NUM_CH,
  parameter int LW  = gpal_pkg::LEG_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  input  logic [NCH-1:0][CW-1:0]      in_ch,
  input  logic                        mode_split,
  input  logic [NCH-1:0][CLW-1:0]     limits,
  output logic [1:0][NCH-1:0][AW-1:0] tbl_addr,
  input  logic [1:0][NCH-1:0][CW-1:0] tbl_rdata,
  output logic                        out_valid,
  output logic [NCH-1:0][CW-1:0]      out_ch
);
  logic               v1_q, v2_q, split1_q, split2_q;
  logic [NCH-1:0]     full1_q, full2_q;
  logic [NCH-1:0][CW-1:0] leg2_q;

  // stage 0 addresses first table, stage 1 addresses second table
  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      tbl_addr[0][c] = mode_split ? in_ch[c][CW-1 -: AW] : AW'(in_ch[c][CW-1 -: LW]);
      tbl_addr[1][c] = tbl_rdata[0][c][CW-1 -: AW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
    end else begin
      v1_q <= in_valid;
      v2_q <= v1_q;
    end
  end

  always_ff @(posedge clk) begin
    split1_q <= mode_split;
    split2_q <= split1_q;
    full2_q  <= full1_q;
    for (int c = 0; c < NCH; c++) begin
      full1_q[c] <= (in_ch[c] == {CW{1'b1}});
      leg2_q[c]  <= tbl_rdata[0][c];
    end
  end

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      if (!split2_q)       out_ch[c] = leg2_q[c];
      else if (full2_q[c]) out_ch[c] = limits[c][CLW-1 -: CW];
      else                 out_ch[c] = tbl_rdata[1][c];
    end
  end

  assign out_valid = v2_q;
endmodule

// File: rtl/gamma_palette.sv
module gamma_palette #(
  parameter int CW  = gpal_pkg::CH_W,
  parameter int AW  = gpal_pkg::TBL_AW,
  parameter int CLW = gpal_pkg::LIM_W,
  parameter int RAW = gpal_pkg::REG_AW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reg_wr,
  input  logic           reg_rd,
  input  logic [RAW-1:0] reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  input  logic           pix_in_valid,
  input  logic [CW-1:0]  pix_in_r,
  input  logic [CW-1:0]  pix_in_g,
  input  logic [CW-1:0]  pix_in_b,
  output logic           pix_out_valid,
  output logic [CW-1:0]  pix_out_r,
  output logic [CW-1:0]  pix_out_g,
  output logic [CW-1:0]  pix_out_b
);
  localparam int NCH   = gpal_pkg::NUM_CH;
  localparam int NBANK = 2;

  logic [NBANK-1:0]                 host_en;
  logic                             host_we;
  logic [AW-1:0]                    host_addr;
  logic [NCH-1:0][CW-1:0]           host_wdata;
  logic [NBANK-1:0][NCH-1:0][CW-1:0] host_rdata;
  logic [NBANK-1:0][NCH-1:0][AW-1:0] look_addr;
  logic [NBANK-1:0][NCH-1:0][CW-1:0] look_rdata;
  logic                             mode_split;
  logic [NCH-1:0][CLW-1:0]          limits;
  logic [NCH-1:0][CW-1:0]           in_ch, out_ch;

  assign in_ch[0] = pix_in_r;
  assign in_ch[1] = pix_in_g;
  assign in_ch[2] = pix_in_b;
  assign pix_out_r = out_ch[0];
  assign pix_out_g = out_ch[1];
  assign pix_out_b = out_ch[2];

  gpal_host #(.CW(CW), .AW(AW), .CLW(CLW), .NCH(NCH), .RAW(RAW)) u_host (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ram_en(host_en), .ram_we(host_we),
    .ram_addr(host_addr), .ram_wdata(host_wdata), .ram_rdata(host_rdata),
    .mode_split(mode_split), .limits(limits)
  );

  gpal_lookup #(.CW(CW), .AW(AW), .CLW(CLW), .NCH(NCH)) u_look (
    .clk(clk), .rst(rst), .in_valid(pix_in_valid), .in_ch(in_ch),
    .mode_split(mode_split), .limits(limits), .tbl_addr(look_addr),
    .tbl_rdata(look_rdata), .out_valid(pix_out_valid), .out_ch(out_ch)
  );

  // bank 0 = degamma, bank 1 = gamma; one RAM per channel per bank
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      gpal_ram #(.AW(AW), .DW(CW)) u_ram (
        .clk(clk), .a_en(host_en[b]), .a_we(host_we), .a_addr(host_addr),
        .a_wdata(host_wdata[c]), .a_rdata(host_rdata[b][c]),
        .b_addr(look_addr[b][c]), .b_rdata(look_rdata[b][c])
      );
    end
  end
endmodule

// File: rtl/gamma_palette_chk.sv
module gamma_palette_chk #(
  parameter int CW  = gpal_pkg::CH_W,
  parameter int IW  = gpal_pkg::TBL_AW + 1,
  parameter int CLW = gpal_pkg::LIM_W,
  parameter int RAW = gpal_pkg::REG_AW
) (
  input logic           clk,
  input logic           rst,
  input logic           reg_wr,
  input logic           reg_rd,
  input logic [RAW-1:0] reg_addr,
  input logic [31:0]    reg_wdata,
  input logic           pix_in_valid,
  input logic [CW-1:0]  pix_in_r,
  input logic           pix_out_valid,
  input logic [CW-1:0]  pix_out_r,
  input logic [IW-1:0]  idx,
  input logic           split_bit,
  input logic           autoinc,
  input logic           mode_split,
  input logic [CLW-1:0] clamp_r
);
  logic [1:0] cyc;
  always_ff @(posedge clk) begin
    if (rst) cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    (cyc == 2'd0) |-> (idx == '0 && !split_bit && !autoinc && mode_split));

  assert_single_access_R3: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && reg_rd));

  assert_advance_R4: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == RAW'(gpal_pkg::OFF_DATA) && autoinc) |=> idx == IW'($past(idx) + 1'b1));

  assert_hold_index_R4: assert property (@(posedge clk) disable iff (rst)
    ((reg_wr || reg_rd) && reg_addr == RAW'(gpal_pkg::OFF_DATA) && !autoinc) |=> $stable(idx));

  assert_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == RAW'(gpal_pkg::OFF_INDEX) && reg_wdata == 32'd0)
      |=> (!split_bit && !autoinc && idx == '0));

  assert_latency_R11: assert property (@(posedge clk) disable iff (rst)
    (cyc == 2'd3) |-> (pix_out_valid == $past(pix_in_valid, 2)));

  assert_limit_R8: assert property (@(posedge clk) disable iff (rst)
    (cyc == 2'd3 && $past(pix_in_valid, 2) && $past(pix_in_r, 2) == {CW{1'b1}} && $past(mode_split, 2))
      |-> (pix_out_r == clamp_r[CLW-1 -: CW]));
endmodule

bind gamma_palette gamma_palette_chk u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .pix_in_valid(pix_in_valid), .pix_in_r(pix_in_r),
  .pix_out_valid(pix_out_valid), .pix_out_r(pix_out_r), .idx(u_host.idx_q),
  .split_bit(u_host.split_q), .autoinc(u_host.inc_q), .mode_split(u_host.mode_q),
  .clamp_r(u_host.clamp_q[0])
);

// File: tb/gamma_palette_tb.sv
module gamma_palette_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {in_r, in_g, in_b, exp_r, exp_g, exp_b}, default tables and limits, split mode
  localparam logic [59:0] VECS [NVEC] = '{
    {10'd0,    10'd2,    10'd512,  10'd0,    10'd2,    10'd512},
    {10'd100,  10'd101,  10'd1022, 10'd100,  10'd100,  10'd1023},
    {10'd7,    10'd300,  10'd999,  10'd6,    10'd300,  10'd998},
    {10'd1023, 10'd1,    10'd511,  10'd1023, 10'd0,    10'd510},
    {10'd1021, 10'd64,   10'd3,    10'd1020, 10'd64,   10'd2},
    {10'd255,  10'd256,  10'd1020, 10'd254,  10'd256,  10'd1020}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pix_in_valid = 1'b0;
  logic [9:0]  pix_in_r = '0, pix_in_g = '0, pix_in_b = '0;
  logic        pix_out_valid;
  logic [9:0]  pix_out_r, pix_out_g, pix_out_b;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;
  logic [31:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  gamma_palette dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pix_in_valid(pix_in_valid),
    .pix_in_r(pix_in_r), .pix_in_g(pix_in_g), .pix_in_b(pix_in_b),
    .pix_out_valid(pix_out_valid), .pix_out_r(pix_out_r), .pix_out_g(pix_out_g),
    .pix_out_b(pix_out_b)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic pixel(input logic [9:0] r, input logic [9:0] g, input logic [9:0] b,
                       input logic [9:0] er, input logic [9:0] eg, input logic [9:0] eb,
                       input string req);
    @(negedge clk);
    pix_in_valid = 1'b1; pix_in_r = r; pix_in_g = g; pix_in_b = b;
    @(negedge clk);
    pix_in_valid = 1'b0;
    check("R11 valid not yet", {31'd0, pix_out_valid}, 32'd0);
    @(negedge clk);
    check("R11 valid", {31'd0, pix_out_valid}, 32'd1);
    check(req, {2'd0, pix_out_r, pix_out_g, pix_out_b}, {2'd0, er, eg, eb});
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 out valid low", {31'd0, pix_out_valid}, 32'd0);
    reg_read(5'h00, rv); check("R1 index", rv, 32'h0);
    reg_read(5'h1C, rv); check("R1 mode", rv, 32'h1);
    reg_read(5'h10, rv); check("R1 limit red", rv, 32'hFFFF);
    reg_read(5'h14, rv); check("R1 limit green", rv, 32'hFFFF);
    reg_read(5'h18, rv); check("R1 limit blue", rv, 32'hFFFF);

    // R6/R7/R8 vector table on default ramp
    for (int i = 0; i < NVEC; i++) begin
      pixel(VECS[i][59:50], VECS[i][49:40], VECS[i][39:30],
            VECS[i][29:20], VECS[i][19:10], VECS[i][9:0], "R7 R6 vector");
    end

    // R6 default readback, R4 no advance
    reg_write(5'h00, 32'h0000_0005);
    reg_read(5'h04, rv); check("R6 degamma 5", rv, 32'h00A0_280A);
    reg_read(5'h00, rv); check("R4 no advance", rv, 32'h0000_0005);
    reg_write(5'h00, 32'h8000_03FF);
    reg_read(5'h04, rv); check("R6 gamma 511", rv, 32'h3FFF_FFFF);

    // R2/R3/R5 gamma write with advance
    reg_write(5'h00, 32'h8000_8232);
    reg_write(5'h04, 32'h0070_2009);
    reg_read(5'h00, rv); check("R2 R4 index after write", rv, 32'h8000_8233);
    pixel(10'd100, 10'd101, 10'd100, 10'd7, 10'd8, 10'd9, "R5 R7 gamma entry");

    // degamma write, no advance
    reg_write(5'h00, 32'h8000_0014);
    reg_write(5'h04, 32'h2580_03FE);
    reg_read(5'h00, rv); check("R4 index held", rv, 32'h8000_0014);
    pixel(10'd40, 10'd41, 10'd40, 10'd600, 10'd0, 10'd1023, "R3 R7 degamma entry");

    // R5 split flag clear: bit 9 ignored
    reg_write(5'h00, 32'h0000_0214);
    reg_write(5'h04, 32'h0010_0401);
    reg_write(5'h00, 32'h8000_0014);
    reg_read(5'h04, rv); check("R5 degamma hit", rv, 32'h0010_0401);
    reg_write(5'h00, 32'h8000_0214);
    reg_read(5'h04, rv); check("R5 gamma untouched", rv, 32'h0280_A028);

    // R4 wrap and read advance
    reg_write(5'h00, 32'h8000_83FF);
    reg_write(5'h04, 32'h0000_0000);
    reg_read(5'h00, rv); check("R4 wrap", rv, 32'h8000_8000);
    reg_read(5'h04, rv); check("R3 read entry 0", rv, 32'h0000_0000);
    reg_read(5'h00, rv); check("R4 read advance", rv, 32'h8000_8001);

    // R10 clear
    reg_write(5'h00, 32'h0000_0000);
    reg_read(5'h00, rv); check("R10 cleared", rv, 32'h0);
    reg_write(5'h04, 32'h0030_0C03);
    reg_read(5'h00, rv); check("R10 no advance", rv, 32'h0);

    // R8 limit
    reg_write(5'h10, 32'h0000_1234);
    reg_read(5'h10, rv); check("R8 limit readback", rv, 32'h1234);
    reg_read(5'h14, rv); check("R8 other limit", rv, 32'hFFFF);
    pixel(10'd1023, 10'd1023, 10'd1023, 10'd72, 10'd1023, 10'd1023, "R8 clamp");

    // R9 legacy
    reg_write(5'h1C, 32'h0);
    reg_read(5'h1C, rv); check("R9 mode", rv, 32'h0);
    reg_write(5'h00, 32'h0000_0003);
    reg_write(5'h04, 32'h00AA_BBCC);
    reg_read(5'h04, rv); check("R9 legacy readback", rv, 32'h00AA_BBCC);
    pixel(10'd12, 10'd13, 10'd15, 10'd680, 10'd748, 10'd816, "R9 legacy lookup");
    pixel(10'd1023, 10'd1023, 10'd1023, 10'd510, 10'd510, 10'd510, "R9 no clamp");

    // R1 second reset keeps tables
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    reg_read(5'h1C, rv); check("R1 mode after reset", rv, 32'h1);
    reg_read(5'h10, rv); check("R1 limit after reset", rv, 32'hFFFF);
    reg_read(5'h00, rv); check("R1 index after reset", rv, 32'h0);
    reg_write(5'h00, 32'h8000_0003);
    reg_read(5'h04, rv); check("R1 table kept", rv, 32'h2A8B_B330);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule